// File: doc/BRIEF.md
# Serial Control Port for Parameter Memory and Configuration Registers

The block lets a host read and write a 256-word coefficient memory and a small bank of configuration registers through four wires: a bit clock, a serial data input, an active-low frame strobe and a serial data output. A frame opens when the strobe is pulled low. The first bit is a direction flag. Ten address bits follow, and after them come the data bits. The address sets the data width: memory words are 24 bits and registers are 16 bits. The length of a frame therefore depends on what it targets.

All host pins are asynchronous to the system clock. They are resynchronised and the bit-clock edges are detected in the system clock domain. For this reason the bit clock may run freely between frames, or it may be stopped. Readback data leaves on a serial line together with an output-enable. The pad ring uses that enable to three-state the line whenever no read is in progress. The configuration registers are presented as one flat vector to the logic they configure.

Top module: `ctl_port`

## Requirements
- R1: A frame is a direction bit (1 = read, 0 = write), then a 10-bit address MSB first, then data MSB first. Every input bit is taken on a rising bit-clock edge while the strobe is low.
- R2: Addresses 0 to 255 select the coefficient memory with 24-bit data. A read returns the last value written to that address.
- R3: Addresses 256 to 263 select configuration registers with 16-bit data. Register k appears on `cfg_regs[16k+15:16k]`. Writes to addresses 264 and above have no effect, and reads from them return zero.
- R4: A write is applied only when the strobe rises after exactly the expected number of data bits (24 or 16). A frame with fewer data bits is discarded.
- R5: A write frame with more data bits than expected is discarded.
- R6: The strobe going high at any point ends the frame and clears the bit count. The next frame decodes from its own first bit.
- R7: `ctl_dout_en` is high only inside a read frame after its address is complete. It returns low within three system clocks after the strobe rises.
- R8: During a read, the output bit changes only after a falling bit-clock edge. The first data bit appears after the falling edge that follows the last address bit.
- R9: Bit-clock edges while the strobe is high change no stored value.
- R10: If the strobe rise and a bit-clock rise reach the block in the same system clock, the strobe takes priority and that bit is not counted.
- R11: After reset, all registers and memory words are zero and `ctl_dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_sclk | input | 1 | Host bit clock, asynchronous |
| ctl_sdi | input | 1 | Host serial data in |
| ctl_latch_n | input | 1 | Active-low frame strobe |
| ctl_dout | output | 1 | Serial readback data |
| ctl_dout_en | output | 1 | Drive enable for the readback pad (low = high impedance) |
| cfg_regs | output | 128 | Configuration registers, register k at bits 16k+15:16k |

## Verification
The strobe closing a frame and a bit-clock rise can land in the same system clock. When they do, the frame can either commit or be discarded. The bench provokes this by raising the strobe and the bit clock in the same step on the final data bit of a register write. The register must keep its old value, because the strobe wins and the frame counts as short. A follow-up write with the strobe raised one bit period later must then update the register.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_SKIP  = 3'd4
    } frame_st_e;

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic latch_n_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s,
    output logic latch_hi
);

    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b100;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;

    assign raw = {latch_n_i, sdi_i, sclk_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_sig
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign synced[g] = chain_q[STAGES-1];
    end

    logic sclk_prev_d, sclk_prev_q;

    always_comb begin
        sclk_prev_d = synced[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_prev_d;
    end

    assign sclk_rise = synced[0] & ~sclk_prev_q;
    assign sclk_fall = ~synced[0] & sclk_prev_q;
    assign sdi_s     = synced[1];
    assign latch_hi  = synced[2];

endmodule

// File: rtl/ctl_frame.sv
module ctl_frame
    import ctl_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int RAM_DEPTH = 256,
    parameter int RAM_W     = 24,
    parameter int REG_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  logic              latch_hi,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [RAM_W-1:0]  rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [RAM_W-1:0]  wr_data,
    output logic              dout,
    output logic              dout_en
);

    localparam int CMD_BITS = ADDR_W + 1;
    localparam int CNT_W    = $clog2(RAM_W + CMD_BITS + 1);
    localparam int PAD_W    = RAM_W - REG_W;

    typedef struct packed {
        frame_st_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] cmd;
        logic [ADDR_W-1:0] addr;
        logic              is_reg;
        logic [RAM_W-1:0]  sh;
        logic              wr;
        logic              dout;
        logic              oe;
    } frame_t;

    frame_t f_d, f_q;
    logic [ADDR_W-1:0] full_addr;
    logic [CNT_W-1:0]  len;
    logic              new_is_reg;

    assign full_addr  = {f_q.cmd[ADDR_W-2:0], sdi_s};
    assign new_is_reg = (full_addr >= ADDR_W'(RAM_DEPTH));
    assign len        = f_q.is_reg ? CNT_W'(REG_W) : CNT_W'(RAM_W);
    assign rd_addr    = full_addr;

    always_comb begin
        f_d    = f_q;
        f_d.wr = 1'b0;
        if (latch_hi) begin
            // strobe high wins over any bit edge in the same cycle
            if (f_q.st == ST_WDATA && f_q.cnt == len) f_d.wr = 1'b1;
            f_d.st  = ST_IDLE;
            f_d.cnt = '0;
            f_d.oe  = 1'b0;
        end else begin
            case (f_q.st)
                ST_IDLE: begin
                    f_d.st  = ST_CMD;
                    f_d.cnt = '0;
                    f_d.cmd = '0;
                end
                ST_CMD: begin
                    if (sclk_rise) begin
                        if (f_q.cnt == CNT_W'(CMD_BITS - 1)) begin
                            f_d.addr   = full_addr;
                            f_d.is_reg = new_is_reg;
                            f_d.cnt    = '0;
                            if (f_q.cmd[ADDR_W-1]) begin
                                f_d.st = ST_RDATA;
                                f_d.oe = 1'b1;
                                f_d.sh = new_is_reg ?
                                         {rd_data[REG_W-1:0], {PAD_W{1'b0}}} : rd_data;
                            end else begin
                                f_d.st = ST_WDATA;
                                f_d.sh = '0;
                            end
                        end else begin
                            f_d.cmd = full_addr;
                            f_d.cnt = f_q.cnt + 1'b1;
                        end
                    end
                end
                ST_WDATA: begin
                    if (sclk_rise) begin
                        if (f_q.cnt == len) begin
                            f_d.st = ST_SKIP;
                        end else begin
                            f_d.sh  = {f_q.sh[RAM_W-2:0], sdi_s};
                            f_d.cnt = f_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RDATA: begin
                    if (sclk_fall) begin
                        if (f_q.cnt != len) begin
                            f_d.dout = f_q.sh[RAM_W-1];
                            f_d.sh   = {f_q.sh[RAM_W-2:0], 1'b0};
                            f_d.cnt  = f_q.cnt + 1'b1;
                        end else begin
                            f_d.dout = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q        <= '0;
            f_q.st     <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign wr_en   = f_q.wr;
    assign wr_addr = f_q.addr;
    assign wr_data = f_q.sh;
    assign dout    = f_q.dout;
    assign dout_en = f_q.oe;

endmodule

// File: rtl/ctl_store.sv
module ctl_store #(
    parameter int ADDR_W    = 10,
    parameter int RAM_DEPTH = 256,
    parameter int RAM_W     = 24,
    parameter int REG_W     = 16,
    parameter int NUM_REGS  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [RAM_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [RAM_W-1:0]          rd_data,
    output logic [NUM_REGS*REG_W-1:0] cfg_regs
);

    localparam int RAM_AW = $clog2(RAM_DEPTH);
    localparam int REG_IW = $clog2(NUM_REGS);
    localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(RAM_DEPTH);
    localparam logic [ADDR_W-1:0] REG_END  = ADDR_W'(RAM_DEPTH + NUM_REGS);

    logic [RAM_W-1:0] ram_q  [RAM_DEPTH];
    logic [REG_W-1:0] regs_q [NUM_REGS];

    logic [ADDR_W-1:0] wr_rel, rd_rel;
    logic              wr_ram, wr_reg;

    assign wr_rel = wr_addr - REG_BASE;
    assign rd_rel = rd_addr - REG_BASE;
    assign wr_ram = wr_en && (wr_addr < REG_BASE);
    assign wr_reg = wr_en && (wr_addr >= REG_BASE) && (wr_addr < REG_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
        end else if (wr_ram) begin
            ram_q[wr_addr[RAM_AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (wr_reg) begin
            regs_q[wr_rel[REG_IW-1:0]] <= wr_data[REG_W-1:0];
        end
    end

    always_comb begin
        if (rd_addr < REG_BASE)
            rd_data = ram_q[rd_addr[RAM_AW-1:0]];
        else if (rd_addr < REG_END)
            rd_data = RAM_W'(regs_q[rd_rel[REG_IW-1:0]]);
        else
            rd_data = '0;
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_cfg
        assign cfg_regs[k*REG_W +: REG_W] = regs_q[k];
    end

endmodule

// File: rtl/ctl_port.sv
module ctl_port #(
    parameter int ADDR_W    = 10,
    parameter int RAM_DEPTH = 256,
    parameter int RAM_W     = 24,
    parameter int REG_W     = 16,
    parameter int NUM_REGS  = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_sclk,
    input  logic                      ctl_sdi,
    input  logic                      ctl_latch_n,
    output logic                      ctl_dout,
    output logic                      ctl_dout_en,
    output logic [NUM_REGS*REG_W-1:0] cfg_regs
);

    logic              sclk_rise_s, sclk_fall_s, sdi_s, latch_hi_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [RAM_W-1:0]  rd_data, wr_data;
    logic              wr_en;

    ctl_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (ctl_sclk),
        .sdi_i     (ctl_sdi),
        .latch_n_i (ctl_latch_n),
        .sclk_rise (sclk_rise_s),
        .sclk_fall (sclk_fall_s),
        .sdi_s     (sdi_s),
        .latch_hi  (latch_hi_s)
    );

    ctl_frame #(
        .ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH), .RAM_W(RAM_W), .REG_W(REG_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise_s),
        .sclk_fall (sclk_fall_s),
        .sdi_s     (sdi_s),
        .latch_hi  (latch_hi_s),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dout      (ctl_dout),
        .dout_en   (ctl_dout_en)
    );

    ctl_store #(
        .ADDR_W(ADDR_W), .RAM_DEPTH(RAM_DEPTH), .RAM_W(RAM_W),
        .REG_W(REG_W), .NUM_REGS(NUM_REGS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cfg_regs (cfg_regs)
    );

endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk (
    input logic clk,
    input logic rst_n,
    input logic latch_hi,
    input logic sclk_rise,
    input logic sclk_fall,
    input logic wr_en,
    input logic dout,
    input logic dout_en
);

    // R7: readback enable only follows a cycle with the strobe low
    p_oe_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !$past(latch_hi));

    // R1: readback enable switches on only right after a sampled bit
    p_oe_after_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> $past(sclk_rise));

    // R6: strobe high ends the frame and the drive
    p_abort_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_hi |=> !dout_en);

    // R4: a commit only happens as the strobe closes a frame
    p_wr_at_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(latch_hi));

    // R4: one commit per frame
    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R8: output bit moves only after a falling bit-clock edge
    p_dout_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(dout));

endmodule

bind ctl_port ctl_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_hi  (latch_hi_s),
    .sclk_rise (sclk_rise_s),
    .sclk_fall (sclk_fall_s),
    .wr_en     (wr_en),
    .dout      (ctl_dout),
    .dout_en   (ctl_dout_en)
);

// File: tb/sim_ctl_port.sv
module sim_ctl_port;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_sclk = 1'b0;
    logic         ctl_sdi = 1'b0;
    logic         ctl_latch_n = 1'b1;
    logic         ctl_dout;
    logic         ctl_dout_en;
    logic [127:0] cfg_regs;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] exp_reg [8];

    always #4 clk = ~clk;

    ctl_port u0 (
        .clk(clk), .rst_n(rst_n), .ctl_sclk(ctl_sclk), .ctl_sdi(ctl_sdi),
        .ctl_latch_n(ctl_latch_n), .ctl_dout(ctl_dout),
        .ctl_dout_en(ctl_dout_en), .cfg_regs(cfg_regs)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < 8; k++)
            check(req, 32'(cfg_regs[k*16 +: 16]), 32'(exp_reg[k]));
    endtask

    task automatic send_bit(input logic b);
        ctl_sdi = b;
        tick(4);
        ctl_sclk = 1'b1;
        tick(4);
        ctl_sclk = 1'b0;
    endtask

    // nd data bits; coinc raises the strobe together with the last bit clock
    task automatic xfer(input logic rw, input logic [9:0] a, input logic [23:0] wd,
                        input int nd, input bit coinc,
                        output logic [23:0] rd, output logic oe_ok);
        logic [10:0] cmd;
        cmd   = {rw, a};
        rd    = '0;
        oe_ok = 1'b1;
        ctl_latch_n = 1'b0;
        tick(4);
        for (int i = 10; i >= 0; i--) send_bit(cmd[i]);
        for (int i = 0; i < nd; i++) begin
            int idx;
            idx = nd - 1 - i;
            ctl_sdi = (!rw && idx >= 0 && idx < 24) ? wd[idx] : 1'b0;
            tick(4);
            rd = {rd[22:0], ctl_dout};
            if (ctl_dout_en !== rw) oe_ok = 1'b0;
            ctl_sclk = 1'b1;
            if (coinc && i == nd - 1) ctl_latch_n = 1'b1;
            tick(4);
            ctl_sclk = 1'b0;
        end
        tick(4);
        ctl_latch_n = 1'b1;
        tick(8);
    endtask

    task automatic wr(input logic [9:0] a, input logic [23:0] d, input int nd);
        logic [23:0] rd;
        logic oe;
        xfer(1'b0, a, d, nd, 1'b0, rd, oe);
    endtask

    task automatic rdw(input logic [9:0] a, input int nd, output logic [23:0] v, output logic oe);
        xfer(1'b1, a, 24'h0, nd, 1'b0, v, oe);
    endtask

    task automatic t_reset;
        logic [23:0] v;
        logic oe;
        check("R11 dout_en", 32'(ctl_dout_en), 0);
        check_regs("R11 regs");
        rdw(10'd5, 24, v, oe);
        check("R11 ram zero", 32'(v), 0);
    endtask

    task automatic t_ram;
        logic [23:0] v;
        logic oe;
        wr(10'd5, 24'hA5C3E1, 24);
        wr(10'd255, 24'h123456, 24);
        rdw(10'd5, 24, v, oe);
        check("R2 R1 ram 5", 32'(v), 32'hA5C3E1);
        check("R7 R8 oe during read", 32'(oe), 1);
        rdw(10'd255, 24, v, oe);
        check("R2 ram 255", 32'(v), 32'h123456);
        check("R7 oe idle after read", 32'(ctl_dout_en), 0);
    endtask

    task automatic t_regs;
        logic [23:0] v;
        logic oe;
        wr(10'd256, 24'h00BEEF, 16); exp_reg[0] = 16'hBEEF;
        wr(10'd263, 24'h001234, 16); exp_reg[7] = 16'h1234;
        check_regs("R3 reg write");
        rdw(10'd256, 16, v, oe);
        check("R3 reg read", 32'(v[15:0]), 32'hBEEF);
        wr(10'd300, 24'h00FFFF, 16);
        check_regs("R3 unmapped write");
        rdw(10'd300, 16, v, oe);
        check("R3 unmapped read", 32'(v[15:0]), 0);
    endtask

    task automatic t_len;
        wr(10'd257, 24'h00AAAA, 15);
        check_regs("R4 short frame");
        wr(10'd256, 24'h015555, 17);
        check_regs("R5 long frame");
    endtask

    task automatic t_abort;
        ctl_latch_n = 1'b0;
        tick(4);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        ctl_latch_n = 1'b1;
        tick(8);
        check("R6 oe after abort", 32'(ctl_dout_en), 0);
        wr(10'd258, 24'h00C0DE, 16); exp_reg[2] = 16'hC0DE;
        check_regs("R6 frame after abort");
    endtask

    task automatic t_free_clk;
        logic [23:0] v;
        logic oe;
        for (int i = 0; i < 40; i++) begin
            ctl_sdi = i[1];
            tick(3);
            ctl_sclk = ~ctl_sclk;
        end
        ctl_sclk = 1'b0;
        tick(8);
        check_regs("R9 free clock");
        rdw(10'd258, 16, v, oe);
        check("R9 read after free clock", 32'(v[15:0]), 32'hC0DE);
    endtask

    task automatic t_coinc;
        logic [23:0] rd;
        logic oe;
        xfer(1'b0, 10'd259, 24'h007777, 16, 1'b1, rd, oe);
        check_regs("R10 coincident close");
        wr(10'd259, 24'h007777, 16); exp_reg[3] = 16'h7777;
        check_regs("R10 normal close");
    endtask

    initial begin
        for (int k = 0; k < 8; k++) exp_reg[k] = '0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_ram();
        t_regs();
        t_len();
        t_abort();
        t_free_clk();
        t_coinc();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule